// File: doc/BRIEF.md
# Shared Address/Data Bus Splitter

This block connects a processor whose low address bits and data share one set of 16 pins to a memory port that has separate address, data and per-byte strobe signals. At the start of each bus cycle the processor places the low 16 address bits on the shared pins and raises an address strobe. The block captures those bits, together with four upper address lines and an active-low high-byte enable, and holds all of them while the same pins carry data.

From the held high-byte enable and address bit 0 the block works out which of the two byte lanes take part in the transfer. During a write it passes the shared pins to the memory write data and pulses a write enable for each active lane while the write strobe is low. During a read it places memory read data onto the shared pins, with a separate output enable for each lane, only while the read strobe is low and only on the active lanes. An external pad ring turns the output enables into tristate drivers.

Top module: `addr_data_demux`

## Requirements
- R1: While `ale_i` is high, `mem_addr_o` equals `{a_hi_i, ad_i}` in the same cycle.
- R2: After `ale_i` falls, `mem_addr_o[15:0]` keeps the value `ad_i` had at the last rising clock edge with `ale_i` high, whatever `ad_i` does afterwards, until `ale_i` rises again.
- R3: The upper four bits `mem_addr_o[19:16]` are captured at the same edge as the low bits and are also held while `a_hi_i` changes.
- R4: `lane_en_o` bit 0 selects the low byte (bits 7:0) and bit 1 the high byte (bits 15:8). With the captured `bhe_n_i`=0 and address bit 0 = 0, it is 2'b11. With `bhe_n_i`=0 and bit 0 = 1, it is 2'b10. With `bhe_n_i`=1 and bit 0 = 0, it is 2'b01. With both at 1, it is 2'b00.
- R5: `ad_oe_o[k]` is 1 only while `rd_n_i` is 0 and lane k is enabled. `ad_o` carries `mem_rdata_i` on enabled lanes and zero on the other lanes.
- R6: `mem_we_o[k]` is 1 only while `wr_n_i` is 0 and lane k is enabled. `mem_wdata_o` follows `ad_i`.
- R7: While `rst_n` is low, `mem_addr_o` is 0, `lane_en_o` is 2'b01 and `ad_oe_o` and `mem_we_o` are 0, provided that `ale_i` is low and the strobes are high.
- R8: A change of `bhe_n_i` after `ale_i` falls does not change `lane_en_o` until the next address strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ad_i | input | 16 | Shared pins: low address, then write data |
| a_hi_i | input | 4 | Upper address lines |
| ale_i | input | 1 | Address strobe, active high |
| bhe_n_i | input | 1 | High-byte enable, active low |
| rd_n_i | input | 1 | Read strobe, active low |
| wr_n_i | input | 1 | Write strobe, active low |
| ad_o | output | 16 | Read data driven toward the shared pins |
| ad_oe_o | output | 2 | Per-lane output enable for the shared pins |
| mem_addr_o | output | 20 | Stable memory address |
| lane_en_o | output | 2 | Active byte lanes of the current cycle |
| mem_wdata_o | output | 16 | Memory write data |
| mem_we_o | output | 2 | Per-lane memory write enable |
| mem_rdata_i | input | 16 | Memory read data |

## Verification
The hardest case to reach is a cycle in which the shared pins, the upper address lines and the high-byte enable all change after the address strobe falls. In that case only the held copies may decide the address and the lanes. Each bench cycle therefore drives unrelated data on the pins and inverted values on the upper lines and the enable during the data phase, and checks the address and lanes again. Each of the four enable and bit-0 combinations is run as both a read and a write, so that lane gating is seen in both directions.

// File: rtl/demux_pkg.sv
package demux_pkg;
  parameter int DATA_W = 16;
  parameter int HI_W   = 4;
  localparam int LANES  = DATA_W / 8;
  localparam int ADDR_W = DATA_W + HI_W;

  typedef logic [LANES-1:0] lane_t;

  // bit0 = low byte, bit1 = high byte
  function automatic lane_t lane_sel(input logic bhe_n, input logic a0);
    lane_t l;
    l[0] = ~a0;
    l[1] = ~bhe_n;
    return l;
  endfunction
endpackage

// File: rtl/addr_hold.sv
module addr_hold #(
  parameter int LO_W = 16,
  parameter int HI_W = 4,
  localparam int AW  = LO_W + HI_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ale,
  input  logic [LO_W-1:0] lo,
  input  logic [HI_W-1:0] hi,
  input  logic          bhe_n,
  output logic [AW-1:0] addr,
  output logic          bhe_n_q
);
  logic [AW-1:0] addr_q, addr_d;
  logic          bhe_d, bhe_q;

  always_comb begin
    addr_d = addr_q;
    bhe_d  = bhe_q;
    if (ale) begin
      addr_d = {hi, lo};
      bhe_d  = bhe_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      bhe_q  <= 1'b1;
    end else begin
      addr_q <= addr_d;
      bhe_q  <= bhe_d;
    end
  end

  // transparent while strobe is high
  assign addr    = ale ? {hi, lo} : addr_q;
  assign bhe_n_q = ale ? bhe_n : bhe_q;
endmodule

// File: rtl/data_steer.sv
module data_steer
  import demux_pkg::*;
#(
  parameter int DW = DATA_W,
  localparam int NL = DW / 8
) (
  input  logic [NL-1:0] lanes,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic [DW-1:0] bus_in,
  input  logic [DW-1:0] rdata,
  output logic [DW-1:0] bus_out,
  output logic [NL-1:0] bus_oe,
  output logic [DW-1:0] wdata,
  output logic [NL-1:0] we
);
  for (genvar g = 0; g < NL; g++) begin : g_lane
    always_comb begin
      bus_oe[g]          = lanes[g] & ~rd_n;
      we[g]              = lanes[g] & ~wr_n;
      bus_out[g*8 +: 8]  = bus_oe[g] ? rdata[g*8 +: 8] : 8'h00;
    end
  end
  assign wdata = bus_in;
endmodule

// File: rtl/addr_data_demux.sv
module addr_data_demux
  import demux_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] ad_i,
  input  logic [HI_W-1:0]   a_hi_i,
  input  logic              ale_i,
  input  logic              bhe_n_i,
  input  logic              rd_n_i,
  input  logic              wr_n_i,
  output logic [DATA_W-1:0] ad_o,
  output logic [LANES-1:0]  ad_oe_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [LANES-1:0]  lane_en_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic [LANES-1:0]  mem_we_o,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  logic bhe_n_held;

  addr_hold #(.LO_W(DATA_W), .HI_W(HI_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .ale(ale_i), .lo(ad_i), .hi(a_hi_i),
    .bhe_n(bhe_n_i), .addr(mem_addr_o), .bhe_n_q(bhe_n_held)
  );

  assign lane_en_o = lane_sel(bhe_n_held, mem_addr_o[0]);

  data_steer #(.DW(DATA_W)) u_steer (
    .lanes(lane_en_o), .rd_n(rd_n_i), .wr_n(wr_n_i), .bus_in(ad_i),
    .rdata(mem_rdata_i), .bus_out(ad_o), .bus_oe(ad_oe_o),
    .wdata(mem_wdata_o), .we(mem_we_o)
  );
endmodule

// File: rtl/addr_data_demux_chk.sv
module addr_data_demux_chk
  import demux_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [DATA_W-1:0] ad_i,
  input logic [HI_W-1:0]   a_hi_i,
  input logic              ale_i,
  input logic              rd_n_i,
  input logic              wr_n_i,
  input logic [LANES-1:0]  ad_oe_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [LANES-1:0]  lane_en_o,
  input logic [LANES-1:0]  mem_we_o
);
  assert_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ale_i) |-> mem_addr_o == {$past(a_hi_i), $past(ad_i)});

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ale_i && $past(!ale_i)) |-> $stable(mem_addr_o));

  assert_odd_lane_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_addr_o[0] |-> !lane_en_o[0]);

  assert_oe_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ad_oe_o != '0) |-> (!rd_n_i && ((ad_oe_o & ~lane_en_o) == '0)));

  assert_we_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we_o != '0) |-> (!wr_n_i && ((mem_we_o & ~lane_en_o) == '0)));
endmodule

bind addr_data_demux addr_data_demux_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ad_i(ad_i), .a_hi_i(a_hi_i), .ale_i(ale_i),
  .rd_n_i(rd_n_i), .wr_n_i(wr_n_i), .ad_oe_o(ad_oe_o),
  .mem_addr_o(mem_addr_o), .lane_en_o(lane_en_o), .mem_we_o(mem_we_o)
);

// File: tb/addr_data_demux_test.sv
module addr_data_demux_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] ad_i, ad_o, mem_wdata_o, mem_rdata_i;
  logic [3:0]  a_hi_i;
  logic        ale_i, bhe_n_i, rd_n_i, wr_n_i;
  logic [1:0]  ad_oe_o, lane_en_o, mem_we_o;
  logic [19:0] mem_addr_o;
  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  addr_data_demux uut (
    .clk(clk), .rst_n(rst_n), .ad_i(ad_i), .a_hi_i(a_hi_i), .ale_i(ale_i),
    .bhe_n_i(bhe_n_i), .rd_n_i(rd_n_i), .wr_n_i(wr_n_i), .ad_o(ad_o),
    .ad_oe_o(ad_oe_o), .mem_addr_o(mem_addr_o), .lane_en_o(lane_en_o),
    .mem_wdata_o(mem_wdata_o), .mem_we_o(mem_we_o), .mem_rdata_i(mem_rdata_i)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; ale_i = 0; rd_n_i = 1; wr_n_i = 1; bhe_n_i = 0;
    ad_i = 16'h1234; a_hi_i = 4'h5; mem_rdata_i = 16'hFFFF;
    repeat (3) @(negedge clk);
    #1;
    check("R7 addr", {12'b0, mem_addr_o}, 32'h0);
    check("R7 lanes", {30'b0, lane_en_o}, 32'h1);
    check("R7 oe/we", {28'b0, ad_oe_o, mem_we_o}, 32'h0);
    @(negedge clk); rst_n = 1'b1;
  endtask

  // one complete bus cycle; checks R1..R6 and R8
  task automatic t_cycle(input logic [19:0] a, input logic bhe, input logic rd,
                         input logic [15:0] data);
    logic [1:0]  exp_l;
    logic [15:0] mask;
    exp_l = {~bhe, ~a[0]};
    mask  = {{8{exp_l[1]}}, {8{exp_l[0]}}};
    @(negedge clk);
    ale_i = 1; ad_i = a[15:0]; a_hi_i = a[19:16]; bhe_n_i = bhe;
    #1;
    check("R1 transparent", {12'b0, mem_addr_o}, {12'b0, a});
    check("R4 lanes addr phase", {30'b0, lane_en_o}, {30'b0, exp_l});
    @(negedge clk);
    ale_i = 0; ad_i = ~a[15:0]; a_hi_i = ~a[19:16]; bhe_n_i = ~bhe;
    mem_rdata_i = data;
    #1;
    check("R2 low held", {16'b0, mem_addr_o[15:0]}, {16'b0, a[15:0]});
    check("R3 high held", {28'b0, mem_addr_o[19:16]}, {28'b0, a[19:16]});
    check("R8 lanes held", {30'b0, lane_en_o}, {30'b0, exp_l});
    check("R5/R6 idle", {28'b0, ad_oe_o, mem_we_o}, 32'h0);
    @(negedge clk);
    if (rd) rd_n_i = 0; else begin wr_n_i = 0; ad_i = data; end
    #1;
    if (rd) begin
      check("R5 oe", {30'b0, ad_oe_o}, {30'b0, exp_l});
      check("R5 data", {16'b0, ad_o}, {16'b0, data & mask});
      check("R6 no we on read", {30'b0, mem_we_o}, 32'h0);
    end else begin
      check("R6 we", {30'b0, mem_we_o}, {30'b0, exp_l});
      check("R6 wdata", {16'b0, mem_wdata_o}, {16'b0, data});
      check("R5 no oe on write", {30'b0, ad_oe_o}, 32'h0);
    end
    @(negedge clk);
    rd_n_i = 1; wr_n_i = 1;
    #1;
    check("R5/R6 release", {28'b0, ad_oe_o, mem_we_o}, 32'h0);
    check("R2 hold end", {12'b0, mem_addr_o}, {12'b0, a});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_cycle(20'hA5C30, 1'b0, 1'b0, 16'hBEEF); // word write
    t_cycle(20'h3F0F2, 1'b0, 1'b1, 16'hC0DE); // word read
    t_cycle(20'h12345, 1'b0, 1'b1, 16'h9A7E); // odd byte read
    t_cycle(20'hF0001, 1'b0, 1'b0, 16'h5511); // odd byte write
    t_cycle(20'h0ABC6, 1'b1, 1'b1, 16'h7788); // even byte read
    t_cycle(20'hC3218, 1'b1, 1'b0, 16'h66AA); // even byte write
    t_cycle(20'h8765B, 1'b1, 1'b1, 16'hFFFF); // no lane read
    t_cycle(20'h00003, 1'b1, 1'b0, 16'h1357); // no lane write
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule